// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a byte-wide asynchronous write bus and an embedded flash array. It watches the chip-select and write-strobe pins, captures each bus write, and steps a small sequencer through the address-qualified unlock handshake. From that it recognises three commands: return to array read, enter the identification (signature) read, and bulk erase. The block selects what a read returns: the array, a fixed signature byte picked by low address bits, or the status register of the erase engine.

Bulk erase needs six writes. There is an unlock pair, an erase set-up byte, a second unlock pair, and then a confirm byte. Any write that breaks a sequence drops the decoder back to idle and array read in the same step. A valid confirm sends a one-cycle start strobe to an external erase engine. While that engine reports busy, only the reset byte is honoured. Issued then, the reset byte also sends a one-cycle abort strobe. The strobe pins are synchronised into the system clock before any edge is detected.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `rd_mode` is 2'b00 (array), `sig_data` is 0xFF and neither `erase_start` nor `erase_abort` is high.
- R2: A write window is open while `bus_cs_n` and `bus_we_n` are both low. The address is captured when the window opens, which is at the later of the two falling edges. The data is captured when the window closes. Address changes after the window opens and data changes before it closes have no effect on the captured values.
- R3: A lone write of 0xF0, at any address and in any state, sets `rd_mode` to 2'b00 and returns the sequencer to idle.
- R4: A write of 0xF0 placed directly after an unlock pair (0xAA to 0x5555, then 0x55 to 0x2AAA) is also accepted as reset and sets `rd_mode` to 2'b00.
- R5: An unlock pair followed by 0x90 written to 0x5555 sets `rd_mode` to 2'b01 (signature).
- R6: With `rd_mode` at 2'b01, `sig_data` is 0x20 when address bits 0, 1 and 6 are all low. It is 0xE2 when bit 0 is high and bits 1 and 6 are low. It is 0xFF for any other combination of those bits, and it is 0xFF in every other mode.
- R7: An unlock pair, 0x80 to 0x5555, a second unlock pair, then 0x10 to 0x5555 causes one pulse on `erase_start` and sets `rd_mode` to 2'b10 (status). `rd_mode` stays 2'b10 after the engine finishes.
- R8: A wrong byte or a wrong address in any unlock cycle, whether in the first or the second pair, aborts the sequence with `rd_mode` at 2'b00 and no start pulse. A correct sequence written afterwards is decoded normally.
- R9: If the byte written after the second unlock pair of an erase is not 0x10, the sequence aborts with `rd_mode` at 2'b00 and no start pulse.
- R10: While `eng_busy` is high, every write other than 0xF0 is ignored. `rd_mode` keeps its value and no start pulse is issued, even for a complete erase sequence.
- R11: A write of 0xF0 while `eng_busy` is high produces one pulse on `erase_abort` and sets `rd_mode` to 2'b00. A write of 0xF0 while the engine is idle produces no abort pulse.
- R12: `erase_start` and `erase_abort` are each high for exactly one clock cycle per event and are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Bus address, sampled when a write window opens; bits 0, 1 and 6 also index the signature byte |
| bus_data | input | 8 | Bus write data, sampled when a write window closes |
| bus_cs_n | input | 1 | Active-low chip select (asynchronous) |
| bus_we_n | input | 1 | Active-low write strobe (asynchronous) |
| eng_busy | input | 1 | High while the erase engine is running |
| rd_mode | output | 2 | Read source: 00 array, 01 signature, 10 status |
| sig_data | output | 8 | Signature byte for the current address, 0xFF outside signature mode |
| erase_start | output | 1 | One-cycle strobe that starts a bulk erase |
| erase_abort | output | 1 | One-cycle strobe that stops a running erase |

## Verification
The bench builds the decoder with a 16-bit address and a three-stage synchroniser. The longer synchroniser lets the bench move the address on the bus after a window has opened, still inside the window, and check that the captured value does not follow. The bench also skews chip-select against the write strobe, so the capture has to happen at the later falling edge. A behavioural engine model holds busy for 300 cycles. That span fits a full, ignored six-write erase sequence and a mid-erase reset inside one busy period. Letting a later erase run to completion shows that status read outlives the engine.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'b00,
    RM_SIG    = 2'b01,
    RM_STATUS = 2'b10
  } rd_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_UNL1  = 3'd1,
    SQ_UNL2  = 3'd2,
    SQ_ESET  = 3'd3,
    SQ_EUNL1 = 3'd4,
    SQ_EUNL2 = 3'd5
  } seq_state_e;

  localparam logic [7:0] KEY_BYTE_1   = 8'hAA;
  localparam logic [7:0] KEY_BYTE_2   = 8'h55;
  localparam logic [7:0] OP_RESET     = 8'hF0;
  localparam logic [7:0] OP_SIGNATURE = 8'h90;
  localparam logic [7:0] OP_ERASE_SET = 8'h80;
  localparam logic [7:0] OP_BULK_CONF = 8'h10;

endpackage

// File: rtl/fcd_strobe_sync.sv
module fcd_strobe_sync #(
  parameter int ADDR_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [7:0]        data_in,
  output logic              win_open,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  logic              win_raw;
  logic [SYNC_N:0]   sh;
  logic              win_close;
  logic [ADDR_W-1:0] addr_hold;

  assign win_raw = ~cs_n & ~we_n;

  // sh[SYNC_N-1] is the synchronised level, sh[SYNC_N] its previous value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_N-1:0], win_raw};
  end

  assign win_open  =  sh[SYNC_N-1] & ~sh[SYNC_N];
  assign win_close = ~sh[SYNC_N-1] &  sh[SYNC_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_hold <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_valid  <= 1'b0;
    end else begin
      wr_valid <= win_close;
      if (win_open) addr_hold <= addr_in;
      if (win_close) begin
        wr_addr <= addr_hold;
        wr_data <= data_in;
      end
    end
  end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR_1 = 'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_2 = 'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              eng_busy,
  output rd_mode_e          mode,
  output logic              start_p,
  output logic              abort_p,
  output logic              cmd_reset,
  output logic              seq_miss
);

  seq_state_e state, nxt_state;
  rd_mode_e   nxt_mode;
  logic       go_start, go_abort;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] d,
                               input logic [ADDR_W-1:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  always_comb begin
    nxt_state = state;
    nxt_mode  = mode;
    go_start  = 1'b0;
    go_abort  = 1'b0;
    cmd_reset = 1'b0;
    seq_miss  = 1'b0;
    if (wr_valid) begin
      if (wr_data == OP_RESET) begin
        cmd_reset = 1'b1;
        nxt_state = SQ_IDLE;
        nxt_mode  = RM_ARRAY;
        go_abort  = eng_busy;
      end else if (!eng_busy) begin
        case (state)
          SQ_IDLE:
            if (hit(wr_addr, wr_data, KEY_ADDR_1, KEY_BYTE_1)) nxt_state = SQ_UNL1;
            else seq_miss = 1'b1;
          SQ_UNL1:
            if (hit(wr_addr, wr_data, KEY_ADDR_2, KEY_BYTE_2)) nxt_state = SQ_UNL2;
            else seq_miss = 1'b1;
          SQ_UNL2:
            if (hit(wr_addr, wr_data, KEY_ADDR_1, OP_SIGNATURE)) begin
              nxt_state = SQ_IDLE;
              nxt_mode  = RM_SIG;
            end else if (hit(wr_addr, wr_data, KEY_ADDR_1, OP_ERASE_SET)) begin
              nxt_state = SQ_ESET;
            end else seq_miss = 1'b1;
          SQ_ESET:
            if (hit(wr_addr, wr_data, KEY_ADDR_1, KEY_BYTE_1)) nxt_state = SQ_EUNL1;
            else seq_miss = 1'b1;
          SQ_EUNL1:
            if (hit(wr_addr, wr_data, KEY_ADDR_2, KEY_BYTE_2)) nxt_state = SQ_EUNL2;
            else seq_miss = 1'b1;
          SQ_EUNL2:
            if (hit(wr_addr, wr_data, KEY_ADDR_1, OP_BULK_CONF)) begin
              nxt_state = SQ_IDLE;
              nxt_mode  = RM_STATUS;
              go_start  = 1'b1;
            end else seq_miss = 1'b1;
          default: seq_miss = 1'b1;
        endcase
        if (seq_miss) begin
          nxt_state = SQ_IDLE;
          nxt_mode  = RM_ARRAY;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      mode    <= RM_ARRAY;
      start_p <= 1'b0;
      abort_p <= 1'b0;
    end else begin
      state   <= nxt_state;
      mode    <= nxt_mode;
      start_p <= go_start;
      abort_p <= go_abort;
    end
  end

endmodule

// File: rtl/fcd_sig_rom.sv
module fcd_sig_rom
  import fcd_pkg::*;
#(
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hE2
) (
  input  rd_mode_e   mode,
  input  logic [2:0] sel,   // {A6, A1, A0}
  output logic [7:0] code
);

  function automatic logic [7:0] lookup(input logic [2:0] s);
    case (s)
      3'b000:  return MFR_CODE;
      3'b001:  return DEV_CODE;
      default: return 8'hFF;
    endcase
  endfunction

  assign code = (mode == RM_SIG) ? lookup(sel) : 8'hFF;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                SYNC_N     = 2,
  parameter logic [ADDR_W-1:0] KEY_ADDR_1 = 'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_2 = 'h2AAA,
  parameter logic [7:0]        MFR_CODE   = 8'h20,
  parameter logic [7:0]        DEV_CODE   = 8'hE2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_data,
  input  logic              bus_cs_n,
  input  logic              bus_we_n,
  input  logic              eng_busy,
  output logic [1:0]        rd_mode,
  output logic [7:0]        sig_data,
  output logic              erase_start,
  output logic              erase_abort
);

  logic              win_open;
  logic              wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              cmd_reset;
  logic              seq_miss;
  rd_mode_e          mode;

  fcd_strobe_sync #(.ADDR_W(ADDR_W), .SYNC_N(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (bus_cs_n),
    .we_n     (bus_we_n),
    .addr_in  (bus_addr),
    .data_in  (bus_data),
    .win_open (win_open),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .KEY_ADDR_1(KEY_ADDR_1), .KEY_ADDR_2(KEY_ADDR_2)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .eng_busy  (eng_busy),
    .mode      (mode),
    .start_p   (erase_start),
    .abort_p   (erase_abort),
    .cmd_reset (cmd_reset),
    .seq_miss  (seq_miss)
  );

  fcd_sig_rom #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rom (
    .mode (mode),
    .sel  ({bus_addr[6], bus_addr[1], bus_addr[0]}),
    .code (sig_data)
  );

  assign rd_mode = mode;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rd_mode,
  input logic [7:0] sig_data,
  input logic       erase_start,
  input logic       erase_abort,
  input logic       eng_busy,
  input logic       wr_valid,
  input logic [7:0] wr_data,
  input logic       cmd_reset,
  input logic       seq_miss
);

  p_start_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  p_abort_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    erase_abort |=> !erase_abort);

  p_pulses_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_start && erase_abort));

  p_start_sets_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> rd_mode == 2'b10);

  p_reset_to_array_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> rd_mode == 2'b00);

  p_miss_to_array_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_miss |=> (rd_mode == 2'b00) && !erase_start);

  p_busy_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && eng_busy && wr_data != 8'hF0) |=> $stable(rd_mode) && !erase_start);

  p_abort_needs_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    erase_abort |-> $past(eng_busy) && rd_mode == 2'b00);

  p_sig_idle_ff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_mode != 2'b01) |-> sig_data == 8'hFF);

endmodule

bind flash_cmd_decoder fcd_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_mode     (rd_mode),
  .sig_data    (sig_data),
  .erase_start (erase_start),
  .erase_abort (erase_abort),
  .eng_busy    (eng_busy),
  .wr_valid    (wr_valid),
  .wr_data     (wr_data),
  .cmd_reset   (cmd_reset),
  .seq_miss    (seq_miss)
);

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;

  localparam int CLK_P   = 10;
  localparam int ENG_CYC = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        bus_cs_n = 1'b1;
  logic        bus_we_n = 1'b1;
  logic        eng_busy = 1'b0;
  logic [1:0]  rd_mode;
  logic [7:0]  sig_data;
  logic        erase_start;
  logic        erase_abort;

  int n_run  = 0;
  int n_fail = 0;
  int eng_cnt = 0;
  bit done = 0;
  byte exp_q[$];   // expected strobe events: "S" start, "A" abort

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(16), .SYNC_N(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n), .eng_busy(eng_busy),
    .rd_mode(rd_mode), .sig_data(sig_data),
    .erase_start(erase_start), .erase_abort(erase_abort)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural erase engine
  always @(negedge clk) begin
    if (erase_abort) begin
      eng_busy <= 1'b0; eng_cnt <= 0;
    end else if (erase_start) begin
      eng_busy <= 1'b1; eng_cnt <= ENG_CYC;
    end else if (eng_cnt > 1) eng_cnt <= eng_cnt - 1;
    else if (eng_cnt == 1) begin
      eng_busy <= 1'b0; eng_cnt <= 0;
    end
  end

  // monitor: pops the scoreboard on every strobe (R12)
  always @(negedge clk) begin
    if (rst_n && (erase_start || erase_abort)) begin
      if (erase_start && erase_abort) chk("R12 both strobes", 8'h1, 8'h0);
      else if (exp_q.size() == 0) chk("R12 unexpected strobe", erase_start ? "S" : "A", 8'h0);
      else chk("R12 strobe kind", erase_start ? "S" : "A", exp_q.pop_front());
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_data = d;
    @(negedge clk);
    bus_cs_n = 1'b0; bus_we_n = 1'b0;
    repeat (6) @(negedge clk);
    bus_we_n = 1'b1; bus_cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic unlock();
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
  endtask

  task automatic enter_sig();
    unlock();
    wr(16'h5555, 8'h90);
  endtask

  task automatic erase_seq(input logic [7:0] conf);
    unlock();
    wr(16'h5555, 8'h80);
    unlock();
    wr(16'h5555, conf);
  endtask

  task automatic sig_at(input string tag, input logic [15:0] a, input logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(tag, sig_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mode", {6'd0, rd_mode}, 8'h00);
    chk("R1 sig", sig_data, 8'hFF);
    chk("R1 strobes", {6'd0, erase_start, erase_abort}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5 signature entry, R6 codes
    enter_sig();
    chk("R5 mode sig", {6'd0, rd_mode}, 8'h01);
    sig_at("R6 mfr", 16'h0000, 8'h20);
    sig_at("R6 dev", 16'h0001, 8'hE2);
    sig_at("R6 dev upper bits", 16'hF0A1, 8'hE2);
    sig_at("R6 A1 high", 16'h0002, 8'hFF);
    sig_at("R6 A6 high", 16'h0040, 8'hFF);

    // R3 lone reset
    wr(16'h1234, 8'hF0);
    chk("R3 mode array", {6'd0, rd_mode}, 8'h00);
    sig_at("R6 outside sig", 16'h0000, 8'hFF);

    // R4 reset after unlock
    enter_sig();
    unlock();
    chk("R4 still sig before cmd", {6'd0, rd_mode}, 8'h01);
    wr(16'h5555, 8'hF0);
    chk("R4 mode array", {6'd0, rd_mode}, 8'h00);

    // R8 wrong address in second unlock cycle, then recovery
    enter_sig();
    wr(16'h5555, 8'hAA);
    wr(16'h2AAB, 8'h55);
    chk("R8 bad unlock addr", {6'd0, rd_mode}, 8'h00);
    enter_sig();
    chk("R8 recovery", {6'd0, rd_mode}, 8'h01);
    // R8 wrong byte in second pair of erase
    unlock();
    wr(16'h5555, 8'h80);
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h54);
    chk("R8 bad erase unlock", {6'd0, rd_mode}, 8'h00);

    // R9 wrong confirm
    enter_sig();
    erase_seq(8'h20);
    chk("R9 bad confirm", {6'd0, rd_mode}, 8'h00);
    chk("R9 engine idle", {7'd0, eng_busy}, 8'h00);

    // R7 valid bulk erase
    exp_q.push_back("S");
    erase_seq(8'h10);
    chk("R7 mode status", {6'd0, rd_mode}, 8'h02);
    chk("R7 engine started", {7'd0, eng_busy}, 8'h01);

    // R10 busy: writes ignored
    enter_sig();
    chk("R10 sig ignored", {6'd0, rd_mode}, 8'h02);
    erase_seq(8'h10);
    chk("R10 erase ignored", {6'd0, rd_mode}, 8'h02);
    chk("R10 queue empty", exp_q.size()[7:0], 8'h00);

    // R11 reset while busy aborts
    exp_q.push_back("A");
    wr(16'h0000, 8'hF0);
    chk("R11 mode array", {6'd0, rd_mode}, 8'h00);
    chk("R11 engine stopped", {7'd0, eng_busy}, 8'h00);

    // R2 skewed strobes: address taken at later fall, data at close
    bus_addr = 16'h1111; bus_data = 8'h00;
    @(negedge clk);
    bus_we_n = 1'b0;
    repeat (5) @(negedge clk);
    bus_addr = 16'h5555;
    bus_cs_n = 1'b0;
    repeat (6) @(negedge clk);
    bus_addr = 16'h0000;
    bus_data = 8'hAA;
    repeat (4) @(negedge clk);
    bus_cs_n = 1'b1;
    repeat (8) @(negedge clk);
    bus_we_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(16'h2AAA, 8'h55);
    wr(16'h5555, 8'h90);
    chk("R2 capture timing", {6'd0, rd_mode}, 8'h01);

    // R7 status persists after completion, R11 idle reset gives no abort
    exp_q.push_back("S");
    erase_seq(8'h10);
    repeat (ENG_CYC + 20) @(negedge clk);
    chk("R7 engine done", {7'd0, eng_busy}, 8'h00);
    chk("R7 status kept", {6'd0, rd_mode}, 8'h02);
    wr(16'h0000, 8'hF0);
    chk("R11 idle reset mode", {6'd0, rd_mode}, 8'h00);
    repeat (5) @(negedge clk);
    chk("R12 all strobes seen", exp_q.size()[7:0], 8'h00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule